// File: doc/BRIEF.md
# Polyphase Coefficient Table Loader

This block fills the horizontal and vertical coefficient memories of a polyphase scaler. The coefficients come from a ROM inside the block that holds five sets of 96 taps. When software or a display pipeline commits a new pair of set selections, the loader compares them with the pair it last applied. It then streams only what is needed over a two-register write port: first a control word to the address register that picks the target tables and a start address of zero, and then the 96 taps in order to the data register.

When both selections name the same set and at least one of them has changed, a single pass loads both tables together. In every other case the vertical table is loaded first and then the horizontal one, and each is loaded only if its own selection changed. A selection outside 1..5 is refused: the block raises an error with its completion pulse and makes no writes. The remembered selections start at 0, so the first valid commit always loads. They are updated only when a commit completes without error. Every accepted commit, including one that needs no writes, ends with exactly one completion pulse.

Top module: `coef_table_loader`

## Requirements
- R1: After reset, `busy`, `wrValid`, `done` and `err` are all low.
- R2: When `hSel == vSel` and either differs from the last applied pair, one pass is written. It has a control word 0xC000 (bit 15 = vertical table, bit 14 = horizontal table, bits 6:0 = start address 0) at address 0x0, followed by 96 data writes at address 0x4.
- R3: Tap k (0..95) of set index s (1..5) is written as a 14-bit two's-complement value zero-extended to 16 bits. With d = |k − 48|, the value is (4096 − 2·d²) shifted arithmetically right by s−1. Set 1, tap 48 therefore carries unity gain, 0x1000.
- R4: When the selections differ and both changed, the vertical pass (control word 0x8000, set `vSel`) is written first and the horizontal pass (control word 0x4000, set `hSel`) follows.
- R5: When the selections differ and only one changed, only that table's pass is written.
- R6: A valid commit whose pair equals the last applied pair makes no writes, and `done` is high in the first cycle after the commit edge.
- R7: A commit with either selection outside 1..5 makes no writes and raises `err` in the same cycle as `done`. The last applied pair stays unchanged.
- R8: While `wrReady` is low, a pending write keeps `wrValid`, `wrAddr` and `wrData` steady, and the sequence of accepted writes is unchanged.
- R9: `done` is a one-cycle pulse, given once per accepted commit. `busy` is high from the commit until `done`, and a `commit` seen while busy is ignored.
- R10: With `wrReady` held high, `done` comes 98 cycles after the commit edge for one pass and 195 cycles after it for two passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commit | input | 1 | Single-cycle request to apply `hSel`/`vSel` |
| hSel | input | 3 | Horizontal coefficient set index (1..5) |
| vSel | input | 3 | Vertical coefficient set index (1..5) |
| wrReady | input | 1 | Register port accepts the pending write |
| wrValid | output | 1 | A register write is pending |
| wrAddr | output | 4 | Register offset: 0x0 address register, 0x4 data register |
| wrData | output | 16 | Control word or coefficient |
| busy | output | 1 | A commit is being processed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion is a rejection (valid with `done`) |

## Verification
The first write is pending in the cycle right after the edge that samples `commit`. With `wrReady` high, each following cycle carries one write. `done` rises in cycle 1 when no writes are needed, in cycle 98 after one pass and in cycle 195 after two. Each commit task counts falling edges from the commit edge and compares the count against these figures. It logs every write accepted at a falling edge, where `wrValid && wrReady` is stable, and then compares the whole log with a sequence built from the requirements. In the stalled run only the log is compared, because a stall moves the latency but not the order of the writes.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  // Register offsets on the write port.
  localparam int ADDR_REG_OFS = 'h0;
  localparam int DATA_REG_OFS = 'h4;
  // Start address of a table load and the mask applied to it.
  localparam int START_ADDR = 0;
  localparam int START_MASK = 'h7F;

  typedef struct packed {
    logic selAddrWord;
    logic clrCnt;
    logic incCnt;
  } dpStrobe_t;
endpackage

// File: rtl/loader_dpath.sv
module loader_dpath
  import coef_loader_pkg::*;
#(
  parameter int NSETS  = 5,
  parameter int TAPS   = 96,
  parameter int COEF_W = 14,
  parameter int DATA_W = 16,
  parameter int AW     = 4,
  localparam int SEL_W = $clog2(NSETS + 1),
  localparam int CNT_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEL_W-1:0]  curSet,
  input  logic [1:0]        dirBits,
  output logic              lastEntry,
  output logic [AW-1:0]     wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int CENTER = TAPS / 2;
  localparam int PEAK   = 1 << (COEF_W - 2);

  function automatic logic [COEF_W-1:0] coefAt(int s, int k);
    int d;
    int v;
    d = (k >= CENTER) ? (k - CENTER) : (CENTER - k);
    v = PEAK - 2 * d * d;
    v = v >>> s;
    return v[COEF_W-1:0];
  endfunction

  logic [COEF_W-1:0] romTbl [NSETS][TAPS];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign romTbl[s][k] = coefAt(s, k);
    end
  end

  logic [CNT_W-1:0] tapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               tapCnt <= '0;
    else if (strobe.clrCnt)  tapCnt <= '0;
    else if (strobe.incCnt)  tapCnt <= tapCnt + 1'b1;
  end

  assign lastEntry = (tapCnt == CNT_W'(TAPS - 1));

  always_comb begin
    if (strobe.selAddrWord) begin
      wrAddr = AW'(ADDR_REG_OFS);
      wrData = {dirBits, (DATA_W-2)'(START_ADDR & START_MASK)};
    end else begin
      wrAddr = AW'(DATA_REG_OFS);
      wrData = DATA_W'(romTbl[curSet][tapCnt]);
    end
  end
endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import coef_loader_pkg::*;
#(
  parameter int NSETS = 5,
  localparam int SEL_W = $clog2(NSETS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commit,
  input  logic [SEL_W-1:0] hSel,
  input  logic [SEL_W-1:0] vSel,
  input  logic             wrReady,
  input  logic             lastEntry,
  output dpStrobe_t        strobe,
  output logic [SEL_W-1:0] curSet,
  output logic [1:0]       dirBits,
  output logic             wrValid,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_FIN} state_t;

  state_t           state;
  logic [SEL_W-1:0] prevH, prevV, reqH, reqV;
  logic             pendH, errFlag;

  function automatic logic inRange(logic [SEL_W-1:0] x);
    return (x >= SEL_W'(1)) && (x <= SEL_W'(NSETS));
  endfunction

  logic hChg, vChg;
  assign hChg = (hSel != prevH);
  assign vChg = (vSel != prevV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      prevH   <= '0;
      prevV   <= '0;
      reqH    <= '0;
      reqV    <= '0;
      pendH   <= 1'b0;
      errFlag <= 1'b0;
      curSet  <= '0;
      dirBits <= 2'b00;
    end else begin
      unique case (state)
        S_IDLE: if (commit) begin
          reqH <= hSel;
          reqV <= vSel;
          if (!inRange(hSel) || !inRange(vSel)) begin
            errFlag <= 1'b1;
            state   <= S_FIN;
          end else begin
            errFlag <= 1'b0;
            if ((hSel == vSel) && (hChg || vChg)) begin
              dirBits <= 2'b11;
              curSet  <= vSel - 1'b1;
              pendH   <= 1'b0;
              state   <= S_ADDR;
            end else if (vChg) begin
              dirBits <= 2'b10;
              curSet  <= vSel - 1'b1;
              pendH   <= hChg;
              state   <= S_ADDR;
            end else if (hChg) begin
              dirBits <= 2'b01;
              curSet  <= hSel - 1'b1;
              pendH   <= 1'b0;
              state   <= S_ADDR;
            end else begin
              state <= S_FIN;
            end
          end
        end
        S_ADDR: if (wrReady) state <= S_DATA;
        S_DATA: if (wrReady && lastEntry) begin
          if (pendH) begin
            dirBits <= 2'b01;
            curSet  <= reqH - 1'b1;
            pendH   <= 1'b0;
            state   <= S_ADDR;
          end else begin
            state <= S_FIN;
          end
        end
        S_FIN: begin
          if (!errFlag) begin
            prevH <= reqH;
            prevV <= reqV;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.selAddrWord = (state == S_ADDR);
    strobe.clrCnt      = (state == S_ADDR);
    strobe.incCnt      = (state == S_DATA) && wrReady;
  end

  assign wrValid = (state == S_ADDR) || (state == S_DATA);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign err     = (state == S_FIN) && errFlag;
endmodule

// File: rtl/coef_table_loader.sv
module coef_table_loader
  import coef_loader_pkg::*;
#(
  parameter int NSETS  = 5,
  parameter int TAPS   = 96,
  parameter int COEF_W = 14,
  parameter int DATA_W = 16,
  parameter int AW     = 4,
  localparam int SEL_W = $clog2(NSETS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commit,
  input  logic [SEL_W-1:0]  hSel,
  input  logic [SEL_W-1:0]  vSel,
  input  logic              wrReady,
  output logic              wrValid,
  output logic [AW-1:0]     wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              err
);
  dpStrobe_t        strobe;
  logic [SEL_W-1:0] curSet;
  logic [1:0]       dirBits;
  logic             lastEntry;

  loader_ctrl #(.NSETS(NSETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .commit(commit), .hSel(hSel), .vSel(vSel),
    .wrReady(wrReady), .lastEntry(lastEntry), .strobe(strobe),
    .curSet(curSet), .dirBits(dirBits), .wrValid(wrValid),
    .busy(busy), .done(done), .err(err)
  );

  loader_dpath #(
    .NSETS(NSETS), .TAPS(TAPS), .COEF_W(COEF_W), .DATA_W(DATA_W), .AW(AW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curSet(curSet),
    .dirBits(dirBits), .lastEntry(lastEntry), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/loader_checker.sv
module loader_checker
  import coef_loader_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrReady,
  input logic [AW-1:0]     wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R8: a stalled write holds its contents
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  // R2: every burst of writes opens at the address register
  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> wrAddr == AW'(ADDR_REG_OFS));

  // R9: completion is a single-cycle pulse that ends the busy period
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R9: no writes outside a busy period
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrValid);

  // R7: rejection only accompanies completion
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done && !wrValid);
endmodule

bind coef_table_loader loader_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (.*);

// File: tb/tb_coef_table_loader.sv
module tb_coef_table_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        commit = 1'b0;
  logic [2:0]  hSel = '0, vSel = '0;
  logic        wrReady = 1'b1;
  logic        wrValid, busy, done, err;
  logic [3:0]  wrAddr;
  logic [15:0] wrData;

  coef_table_loader dut (
    .clk(clk), .rstN(rstN), .commit(commit), .hSel(hSel), .vSel(vSel),
    .wrReady(wrReady), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int logN = 0, doneCnt = 0;
  logic logging = 1'b0;
  logic [3:0]  logA [0:399];
  logic [15:0] logD [0:399];
  int expN;
  logic [3:0]  expA [0:399];
  logic [15:0] expD [0:399];
  int mH = 0, mV = 0;
  logic stallMode = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    wrReady = stallMode ? ((cyc % 3) != 2) : 1'b1;
  end

  always @(negedge clk) if (logging) begin
    if (wrValid && wrReady && logN < 400) begin
      logA[logN] = wrAddr;
      logD[logN] = wrData;
      logN++;
    end
    if (done) doneCnt++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] coefRef(int s0, int k);
    int d, v;
    d = (k >= 48) ? k - 48 : 48 - k;
    v = (4096 - 2 * d * d) >>> s0;
    return {2'b00, v[13:0]};
  endfunction

  task automatic addPass(input logic [1:0] dir, input int s0);
    expA[expN] = 4'h0; expD[expN] = {dir, 14'h0}; expN++;
    for (int k = 0; k < 96; k++) begin
      expA[expN] = 4'h4; expD[expN] = coefRef(s0, k); expN++;
    end
  endtask

  task automatic doCommit(input int h, input int v, input string req,
                          input logic chkLat, input int injectAt);
    logic bad;
    int n, badIdx, expLat;
    logic gotErr;
    expN = 0;
    bad = (h < 1 || h > 5 || v < 1 || v > 5);
    if (!bad) begin
      if (h == v && (h != mH || v != mV)) addPass(2'b11, v - 1);
      else begin
        if (v != mV) addPass(2'b10, v - 1);
        if (h != mH) addPass(2'b01, h - 1);
      end
      mH = h; mV = v;
    end
    expLat = (expN == 0) ? 1 : expN + 1;
    logN = 0; doneCnt = 0; logging = 1'b1;
    @(posedge clk); #1;
    hSel = 3'(h); vSel = 3'(v); commit = 1'b1;
    @(posedge clk); #1;
    commit = 1'b0;
    n = 0; gotErr = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (injectAt != 0 && n == injectAt) begin commit = 1'b1; hSel = 3'd1; vSel = 3'd5; end
      if (injectAt != 0 && n == injectAt + 1) commit = 1'b0;
      if (done) begin gotErr = err; break; end
      if (n > 3000) begin check("R9", "done timeout", n, expLat); break; end
    end
    @(negedge clk);
    check("R9", "done pulse width", int'(done), 0);
    check("R9", "busy after done", int'(busy), 0);
    logging = 1'b0;
    if (chkLat) check(req, "latency", n, expLat);
    check(bad ? "R7" : req, "err flag", int'(gotErr), int'(bad));
    check("R9", "done count", doneCnt, 1);
    check(req, "write count", logN, expN);
    badIdx = -1;
    for (int i = 0; i < expN && i < logN; i++)
      if (badIdx < 0 && (logA[i] != expA[i] || logD[i] != expD[i])) badIdx = i;
    if (badIdx >= 0)
      check("R3", $sformatf("write %0d addr/data", badIdx),
            int'({logA[badIdx], logD[badIdx]}), int'({expA[badIdx], expD[badIdx]}));
    else check("R3", "write contents", 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "busy", int'(busy), 0);
    check("R1", "wrValid", int'(wrValid), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(err), 0);
  endtask

  task automatic t_firstLoad();   doCommit(1, 1, "R2", 1'b1, 0); endtask
  task automatic t_noChange();    doCommit(1, 1, "R6", 1'b1, 0); endtask
  task automatic t_bothChanged(); doCommit(3, 5, "R4", 1'b1, 0); endtask
  task automatic t_oneChanged();  doCommit(2, 5, "R5", 1'b1, 0); endtask
  task automatic t_joinEqual();   doCommit(2, 2, "R10", 1'b1, 0); endtask
  task automatic t_invalid();
    doCommit(0, 2, "R7", 1'b1, 0);
    doCommit(2, 6, "R7", 1'b1, 0);
    doCommit(2, 2, "R7", 1'b1, 0);
  endtask
  task automatic t_stall();
    stallMode = 1'b1;
    doCommit(4, 1, "R8", 1'b0, 0);
    stallMode = 1'b0;
  endtask
  task automatic t_busyCommit();  doCommit(5, 5, "R9", 1'b1, 10); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_firstLoad();
    t_noChange();
    t_bothChanged();
    t_oneChanged();
    t_joinEqual();
    t_invalid();
    t_stall();
    t_busyCommit();
    summary();
    $finish;
  end
endmodule